// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a watchdog timer controlled through one 8-bit register on a simple write-strobe bus. The register reads back combinationally. Software picks a time-out length and an expiry action, then sets the enable bit. From then on the enable, the length and the action are frozen until the next system reset. While the watchdog is enabled, a counter advances on every clock cycle in which the tick-enable input is high. A slower clock source is modelled this way inside the system clock domain. Software has to pulse the refresh input before the count reaches the selected power of two.

When the count expires, the block sets a sticky cause flag. It then does one of two things, as the action bit selects. In the first, it raises a system reset request and holds it until the system reset arrives. In the second, it gives a single-cycle non-maskable interrupt pulse and restarts the count. The cause flag is cleared only by power-on reset or by a write of 1 to that bit. A software reset or a watchdog reset therefore leaves the flag in place, so software can read the cause afterwards.

Register layout: bit 7 is the enable. Bit 6 is the cause flag. Bit 2 is the action (0 = reset request, 1 = interrupt). Bits 1:0 select the period. Bits 5:3 read 0 and writes to them have no effect.

Top module: `lockable_wdt`

## Requirements
- R1: After rst_ni the register reads 8'h00 apart from the cause flag, and both outputs stay low no matter how many ticks arrive.
- R2: A write with bit 7 set enables the watchdog. Once it is enabled, writes with bit 7 clear leave bit 7 reading 1 until rst_ni.
- R3: The period selector in bits 1:0 gives a time-out after 2^P0_EXP, 2^P1_EXP, 2^P2_EXP or 2^P3_EXP ticks for codes 00, 01, 10 and 11. The defaults are 18, 22, 25 and 27.
- R4: Once the watchdog is enabled, writes do not change bits 2:0, and the time-out keeps the length that was selected before enabling.
- R5: A time-out sets bit 6. Writing 1 to bit 6 clears it, and a time-out in the same cycle takes priority over the clear. rst_ni does not clear the flag. por_ni clears it.
- R6: The action bit (bit 2) defaults to 0. With the action bit at 0, a time-out raises wdt_rst_o, and wdt_rst_o stays high until rst_ni is asserted.
- R7: With the action bit at 1, a time-out gives nmi_o for exactly one cycle, and the count restarts from zero.
- R8: A refresh pulse clears the count. A refresh in the same cycle as the final tick prevents the time-out, and a full period is then needed again.
- R9: The count advances only in cycles where tick_i is high. Idle cycles do not move it.
- R10: wdt_rst_o and nmi_o are registered. They change on the clock edge that takes in the final tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset, clears the cause flag |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read-back |
| tick_i | input | 1 | Count enable from the selected time base |
| refresh_i | input | 1 | Single-cycle counter restart |
| wdt_rst_o | output | 1 | System reset request |
| nmi_o | output | 1 | Non-maskable interrupt pulse |

## Verification
The properties assume that refresh_i, tick_i and wr_en_i are synchronous single-cycle levels. They also assume that every period is at least two ticks long, so back-to-back interrupt pulses cannot occur. The stimulus drives every input on the falling edge and builds the bench with periods of 8 to 64 ticks, all well above that minimum. Whenever the flag assertion relies on the power-on reset being released, the bench keeps por_ni high.

// File: rtl/lockable_wdt_pkg.sv
package lockable_wdt_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned FLG_BIT = 6;
  localparam int unsigned MOD_BIT = 2;
  localparam int unsigned NUM_PER = 4;

  typedef enum logic {
    ACT_RESET = 1'b0,
    ACT_NMI   = 1'b1
  } wdt_act_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import lockable_wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic              en_o,
  output wdt_act_e          act_o,
  output logic [1:0]        per_o,
  output logic              flag_o
);
  logic     en_q;
  wdt_act_e act_q;
  logic [1:0] per_q;
  logic     flag_q;
  logic     unused_bits;

  assign unused_bits = ^wdata_i[5:3];

  // enable, action and period are writable only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      act_q <= ACT_RESET;
      per_q <= 2'b00;
    end else if (wr_en_i && !en_q) begin
      en_q  <= wdata_i[EN_BIT];
      act_q <= wdt_act_e'(wdata_i[MOD_BIT]);
      per_q <= wdata_i[1:0];
    end
  end

  // cause flag lives on the power-on domain only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                            flag_q <= 1'b0;
    else if (expire_i)                      flag_q <= 1'b1;
    else if (wr_en_i && wdata_i[FLG_BIT])   flag_q <= 1'b0;
  end

  assign en_o   = en_q;
  assign act_o  = act_q;
  assign per_o  = per_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned P0_EXP = 18,
  parameter int unsigned P1_EXP = 22,
  parameter int unsigned P2_EXP = 25,
  parameter int unsigned P3_EXP = 27,
  localparam int unsigned M01 = (P0_EXP > P1_EXP) ? P0_EXP : P1_EXP,
  localparam int unsigned M23 = (P2_EXP > P3_EXP) ? P2_EXP : P3_EXP,
  localparam int unsigned CW  = (M01 > M23) ? M01 : M23
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] per_i,
  input  logic       tick_i,
  input  logic       refresh_i,
  output logic       expire_o
);
  localparam int unsigned EXPS [lockable_wdt_pkg::NUM_PER] = '{P0_EXP, P1_EXP, P2_EXP, P3_EXP};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_a [lockable_wdt_pkg::NUM_PER];
  logic          at_last;

  for (genvar g = 0; g < lockable_wdt_pkg::NUM_PER; g++) begin : g_last
    assign last_a[g] = CW'((64'd1 << EXPS[g]) - 64'd1);
  end

  assign at_last  = (cnt_q == last_a[per_i]);
  assign expire_o = en_i && tick_i && !refresh_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || refresh_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event
  import lockable_wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     expire_i,
  input  wdt_act_e act_i,
  output logic     wdt_rst_o,
  output logic     nmi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_rst_o <= 1'b0;
      nmi_o     <= 1'b0;
    end else begin
      if (expire_i && act_i == ACT_RESET) wdt_rst_o <= 1'b1;
      nmi_o <= expire_i && act_i == ACT_NMI;
    end
  end
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import lockable_wdt_pkg::*;
#(
  parameter int unsigned P0_EXP = 18,
  parameter int unsigned P1_EXP = 22,
  parameter int unsigned P2_EXP = 25,
  parameter int unsigned P3_EXP = 27
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tick_i,
  input  logic       refresh_i,
  output logic       wdt_rst_o,
  output logic       nmi_o
);
  logic       en, flag, expire;
  wdt_act_e   act;
  logic [1:0] per;

  wdt_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .wdata_i,
    .expire_i(expire), .en_o(en), .act_o(act), .per_o(per), .flag_o(flag)
  );

  wdt_counter #(
    .P0_EXP(P0_EXP), .P1_EXP(P1_EXP), .P2_EXP(P2_EXP), .P3_EXP(P3_EXP)
  ) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .per_i(per), .tick_i, .refresh_i,
    .expire_o(expire)
  );

  wdt_event u_evt (
    .clk_i, .rst_ni, .expire_i(expire), .act_i(act), .wdt_rst_o, .nmi_o
  );

  always_comb begin
    rdata_o          = '0;
    rdata_o[EN_BIT]  = en;
    rdata_o[FLG_BIT] = flag;
    rdata_o[MOD_BIT] = act;
    rdata_o[1:0]     = per;
  end
endmodule

// File: rtl/lockable_wdt_chk.sv
module lockable_wdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       refresh_i,
  input logic [7:0] rdata_o,
  input logic       wdt_rst_o,
  input logic       nmi_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[7] |-> (!wdt_rst_o && !nmi_o));

  p_enable_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |=> rdata_o[7]);

  p_fields_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |=> $stable(rdata_o[2:0]));

  p_flag_on_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (nmi_o || $rose(wdt_rst_o)) |-> rdata_o[6]);

  p_rst_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> wdt_rst_o);

  p_nmi_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);

  p_refresh_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (!nmi_o && !$rose(wdt_rst_o)));
endmodule

bind lockable_wdt lockable_wdt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .refresh_i(refresh_i),
  .rdata_o(rdata_o), .wdt_rst_o(wdt_rst_o), .nmi_o(nmi_o)
);

// File: tb/lockable_wdt_tb.sv
module lockable_wdt_tb;
  localparam int E0 = 3, E1 = 4, E2 = 5, E3 = 6;
  localparam int NV = 8;
  // {action, period code}
  localparam logic [2:0] VEC [NV] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                      3'b100, 3'b101, 3'b110, 3'b111};
  localparam int VLEN [NV] = '{8, 16, 32, 64, 8, 16, 32, 64};

  logic clk = 0, rst_ni = 0, por_ni = 0, wr_en = 0, tick = 0, refresh = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wrst, nmi;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lockable_wdt #(.P0_EXP(E0), .P1_EXP(E1), .P2_EXP(E2), .P3_EXP(E3)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .refresh_i(refresh),
    .wdt_rst_o(wrst), .nmi_o(nmi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic sys_reset();
    rst_ni = 0; @(negedge clk); rst_ni = 1; @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        finish_run();
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1; por_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata after reset", rdata, 8'h00);
    run(200);
    chk("R1 no event while disabled", {wrst, nmi}, 2'b00);

    // R3 R6 R7 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      sys_reset();
      wr(8'h80 | {5'b0, VEC[v]});
      chk("R2 enabled readback", rdata & 8'h87, 8'h80 | {5'b0, VEC[v]});
      run(VLEN[v] - 1);
      chk("R3 no event before period", {wrst, nmi}, 2'b00);
      run(1);
      if (VEC[v][2]) chk("R7 nmi at period", {wrst, nmi}, 2'b01);
      else           chk("R6 rst at period", {wrst, nmi}, 2'b10);
      chk("R5 flag set", rdata[6], 1'b1);
      @(negedge clk);
      if (VEC[v][2]) chk("R7 nmi one cycle", nmi, 1'b0);
      else           chk("R6 rst held", wrst, 1'b1);
      wr(8'h40);
      chk("R5 flag w1c", rdata[6], 1'b0);
    end

    // R6 held until reset, flag survives rst_ni
    sys_reset();
    wr(8'h80);
    run(8);
    repeat (20) @(negedge clk);
    chk("R6 rst still held", wrst, 1'b1);
    sys_reset();
    chk("R6 rst released by rst_ni", wrst, 1'b0);
    chk("R5 flag survives rst_ni", rdata, 8'h40);
    por_ni = 0; @(negedge clk); por_ni = 1; @(negedge clk);
    chk("R5 flag cleared by por", rdata, 8'h00);

    // R2 R4 lock: enable with nmi, period 01 (16 ticks)
    sys_reset();
    wr(8'h85);
    wr(8'h02);
    chk("R2 enable not cleared", rdata[7], 1'b1);
    chk("R4 fields unchanged", rdata[2:0], 3'b101);
    run(15);
    chk("R4 old period no event", nmi, 1'b0);
    run(1);
    chk("R4 old period nmi", nmi, 1'b1);
    // R7 restart: another full period
    run(15);
    chk("R7 restart no early", nmi, 1'b0);
    run(1);
    chk("R7 restart second pulse", nmi, 1'b1);

    // R5 timeout beats clear in same cycle
    run(15);
    tick = 1; wr_en = 1; wdata = 8'h40;
    @(negedge clk);
    tick = 0; wr_en = 0; wdata = '0;
    chk("R5 event beats clear", {nmi, rdata[6]}, 2'b11);
    wr(8'h40);

    // R8 refresh on final tick
    run(15);
    tick = 1; refresh = 1;
    @(negedge clk);
    tick = 0; refresh = 0;
    chk("R8 refresh wins", {nmi, rdata[6]}, 2'b00);
    run(15);
    chk("R8 full period needed", nmi, 1'b0);
    run(1);
    chk("R8 event after full period", nmi, 1'b1);
    // R8 refresh mid-count
    run(10);
    refresh = 1; @(negedge clk); refresh = 0;
    run(15);
    chk("R8 mid refresh clears", nmi, 1'b0);
    run(1);
    chk("R8 event after mid refresh", nmi, 1'b1);

    // R9 idle cycles do not count
    run(15);
    repeat (100) @(negedge clk);
    chk("R9 idle no event", nmi, 1'b0);
    run(1);
    chk("R9 last tick fires", nmi, 1'b1);

    finish_run();
  end
endmodule